// File: doc/BRIEF.md
# Pulse trigger and width controller

This block produces pulses on a timebase of whole clock ticks. A trigger opens a frame that lasts one programmed period. Inside the frame the true output is high from the programmed delay for the programmed width. A one-cycle trigger-out strobe marks the leading edge of every pulse, and a complement output carries the inverse of the pulse. Four trigger sources are available: free running, a rising edge on the external input, the external input used as a level gate, and a software command. A fifth mode passes the synchronized external input straight to the outputs.

Period, delay and width are sampled only when a frame starts, so a pulse in progress always completes with the values it started with. Before use the three values are forced into a legal window. The period is at least two guard bands. The width lies between one guard band and the period minus one guard band. The delay is limited so that the pulse fits inside the frame. Whenever one of these limits changes a sampled value, a sticky flag is set.

The external input passes through a two-flop synchronizer before any use. All latencies below assume the default of two synchronizer stages.

Top module: `pulse_trig_ctrl`

## Requirements
- R1: While rst_ni is low, out_o=0, out_no=1, trig_o=0 and clamp_err_o=0.
- R2: With mode_i=0 (free running), frames start back to back with no gap, so exactly one pulse is emitted every P cycles. The pulse is high for W cycles.
- R3: With mode_i=1 (edge), a rising edge on ext_i starts one frame when no frame is running. out_o rises right after the (D+2)th clock edge following the edge that first samples ext_i high. Edges that arrive while a frame is running are ignored.
- R4: With mode_i=2 (level), frames repeat back to back while the synchronized ext_i is high. Once ext_i is low, the running frame finishes and no further frame starts.
- R5: With mode_i=3 (software), a one-cycle high on sw_trig_i starts exactly one frame when none is running. A command given while a frame is running is ignored.
- R6: With mode_i=4 (external width), out_o after each clock edge equals the value ext_i had at the previous edge. trig_o stays 0 and no frame runs.
- R7: The effective width is W = min(max(width_i, GUARD), P - GUARD).
- R8: The effective period is P = max(period_i, 2*GUARD). The effective delay is D = min(delay_i, P - W).
- R9: clamp_err_o is set when a frame starts with any of P, W or D differing from its input, and it stays set until reset.
- R10: out_no is the inverse of out_o in every cycle.
- R11: In modes 0 to 3, trig_o is high for exactly the first cycle of each pulse and at no other time.
- R12: period_i, width_i and delay_i are sampled only at frame start. A change during a frame does not alter the pulse of that frame.
- R13: mode_i values 5 to 7 hold out_o at 0 and trig_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | 0 free, 1 edge, 2 level, 3 software, 4 external width, 5-7 idle |
| period_i | input | CNT_W | Frame period in ticks |
| delay_i | input | CNT_W | Pulse delay from frame start in ticks |
| width_i | input | CNT_W | Pulse width in ticks |
| sw_trig_i | input | 1 | Software trigger command |
| ext_i | input | 1 | External trigger or gate, asynchronous |
| out_o | output | 1 | True pulse output |
| out_no | output | 1 | Complement pulse output |
| trig_o | output | 1 | Trigger-out strobe |
| clamp_err_o | output | 1 | Sticky flag for clamped settings |

## Verification
The bench builds the block with CNT_W=8, GUARD=2 and SYNC_STAGES=2. With these values, periods of a few dozen ticks complete many frames in a short run, so the restart between back-to-back frames is exercised repeatedly. Random periods that include 0 reach the period floor of 4. Random widths and delays can exceed the period, which drives all three clamps and the delay/width fit limit. The two-stage synchronizer fixes the edge latency at D+2 and the passthrough lag at one edge, and directed cases measure both exactly.

// File: rtl/pulse_trig_pkg.sv
package pulse_trig_pkg;
  typedef enum logic [2:0] {
    MODE_FREE  = 3'd0,
    MODE_EDGE  = 3'd1,
    MODE_LEVEL = 3'd2,
    MODE_SOFT  = 3'd3,
    MODE_EXTW  = 3'd4,
    MODE_RSV5  = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } mode_e;
endpackage

// File: rtl/pulse_trig_sync.sv
module pulse_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pulse_trig_clamp.sv
module pulse_trig_clamp #(
  parameter int CNT_W = 8,
  parameter int GUARD = 2
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] delay_o,
  output logic             clamped_o
);
  localparam logic [CNT_W-1:0] GuardC = CNT_W'(GUARD);
  localparam logic [CNT_W-1:0] PminC  = CNT_W'(2 * GUARD);

  logic [CNT_W-1:0] w_hi, d_hi;

  always_comb begin
    period_o = (period_i < PminC) ? PminC : period_i;
    w_hi     = period_o - GuardC;
    if (width_i < GuardC)     width_o = GuardC;
    else if (width_i > w_hi)  width_o = w_hi;
    else                      width_o = width_i;
    d_hi     = period_o - width_o;
    delay_o  = (delay_i > d_hi) ? d_hi : delay_i;
    clamped_o = (period_o != period_i) || (width_o != width_i) || (delay_o != delay_i);
  end
endmodule

// File: rtl/pulse_trig_engine.sv
module pulse_trig_engine
  import pulse_trig_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GUARD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             gate_i,
  input  logic             rise_i,
  input  logic             sw_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             clamped_i,
  output logic             pulse_o,
  output logic             trig_o,
  output logic             err_o
);
  logic             busy_q, err_q;
  logic [CNT_W-1:0] cnt_q, p_q, w_q, d_q;
  logic             run_mode, fin, cont, launch, again;
  logic [CNT_W:0]   pulse_end;

  assign run_mode  = mode_i inside {MODE_FREE, MODE_EDGE, MODE_LEVEL, MODE_SOFT};
  assign fin       = busy_q && (cnt_q == p_q - 1'b1);
  assign cont      = (mode_i == MODE_FREE) || (mode_i == MODE_LEVEL && gate_i);
  assign launch    = !busy_q && (cont || (mode_i == MODE_EDGE && rise_i) ||
                                 (mode_i == MODE_SOFT && sw_i));
  assign again     = fin && cont;
  assign pulse_end = {1'b0, d_q} + {1'b0, w_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      p_q    <= '0;
      w_q    <= '0;
      d_q    <= '0;
    end else if (!run_mode) begin
      busy_q <= 1'b0;
    end else if (launch || again) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      p_q    <= period_i;
      w_q    <= width_i;
      d_q    <= delay_i;
      err_q  <= err_q | clamped_i;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = run_mode && busy_q && (cnt_q >= d_q) && ({1'b0, cnt_q} < pulse_end);
  assign trig_o  = run_mode && busy_q && (cnt_q == d_q);
  assign err_o   = err_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < p_q));
  p_free_rerun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && mode_i == MODE_FREE) |=> (busy_q && cnt_q == '0));
  p_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (w_q >= CNT_W'(GUARD) && w_q <= p_q - CNT_W'(GUARD)));
  p_fit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (pulse_end <= {1'b0, p_q}));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin && run_mode) |=> ($stable(w_q) && $stable(d_q) && $stable(p_q)));
endmodule

// File: rtl/pulse_trig_ctrl.sv
module pulse_trig_ctrl
  import pulse_trig_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GUARD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             sw_trig_i,
  input  logic             ext_i,
  output logic             out_o,
  output logic             out_no,
  output logic             trig_o,
  output logic             clamp_err_o
);
  mode_e            mode;
  logic             ext_s, ext_d, ext_rise;
  logic [CNT_W-1:0] p_c, w_c, d_c;
  logic             clamped, pulse, strobe;

  assign mode = mode_e'(mode_i);

  pulse_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_i), .q_o(ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ext_d <= 1'b0;
    else         ext_d <= ext_s;

  assign ext_rise = ext_s && !ext_d;

  pulse_trig_clamp #(.CNT_W(CNT_W), .GUARD(GUARD)) u_clamp (
    .period_i(period_i), .width_i(width_i), .delay_i(delay_i),
    .period_o(p_c), .width_o(w_c), .delay_o(d_c), .clamped_o(clamped)
  );

  pulse_trig_engine #(.CNT_W(CNT_W), .GUARD(GUARD)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .gate_i(ext_s), .rise_i(ext_rise), .sw_i(sw_trig_i),
    .period_i(p_c), .width_i(w_c), .delay_i(d_c), .clamped_i(clamped),
    .pulse_o(pulse), .trig_o(strobe), .err_o(clamp_err_o)
  );

  // passthrough mode bypasses the frame engine entirely
  assign out_o  = (mode == MODE_EXTW) ? ext_s : pulse;
  assign out_no = ~out_o;
  assign trig_o = (mode == MODE_EXTW) ? 1'b0 : strobe;

  p_trig_lead_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (out_o && !$past(out_o)));
  p_extw_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_EXTW) |-> !trig_o);
  p_rsv_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 3'd4) |-> (!out_o && !trig_o));
endmodule

// File: tb/pulse_trig_ctrl_tb_top.sv
module pulse_trig_ctrl_tb_top;
  localparam int CW = 8;
  localparam int G  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]    mode = 3'd5;
  logic [CW-1:0] per = 8'd10, dly = 8'd2, wid = 8'd4;
  logic          sw = 1'b0, ext = 1'b0;
  logic          out_o, out_no, trig_o, err_o;

  pulse_trig_ctrl #(.CNT_W(CW), .GUARD(G), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .period_i(per),
    .delay_i(dly), .width_i(wid), .sw_trig_i(sw), .ext_i(ext),
    .out_o(out_o), .out_no(out_no), .trig_o(trig_o), .clamp_err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  int pulse_cnt = 0, run_len = 0, last_w = 0;
  bit last_out = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p < 2*G) ? 2*G : p;
  endfunction
  function automatic int eff_w(input int w, input int p);
    int pe = eff_p(p);
    if (w < G) return G;
    if (w > pe - G) return pe - G;
    return w;
  endfunction
  function automatic int eff_d(input int d, input int w, input int p);
    int lim = eff_p(p) - eff_w(w, p);
    return (d > lim) ? lim : d;
  endfunction

  // reference model written from the requirements
  bit m_s1, m_s2, m_prev, m_run, m_err;
  int m_t, m_P, m_W, m_D;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_run <= 0; m_err <= 0;
      m_t <= 0; m_P <= 0; m_W <= 0; m_D <= 0;
    end else begin
      bit want, at_end;
      m_s1 <= ext; m_s2 <= m_s1; m_prev <= m_s2;
      at_end = m_run && (m_t == m_P - 1);
      if (mode >= 3'd4) m_run <= 0;
      else if (m_run && !at_end) m_t <= m_t + 1;
      else begin
        want = (mode == 3'd0) || (mode == 3'd2 && m_s2) ||
               (!m_run && mode == 3'd1 && m_s2 && !m_prev) ||
               (!m_run && mode == 3'd3 && sw);
        if (want) begin
          m_run <= 1; m_t <= 0;
          m_P <= eff_p(per); m_W <= eff_w(wid, per); m_D <= eff_d(dly, wid, per);
          if (eff_p(per) != per || eff_w(wid, per) != wid || eff_d(dly, wid, per) != dly)
            m_err <= 1;
        end else m_run <= 0;
      end
    end
  end

  function automatic bit m_out();
    if (mode == 3'd4) return m_s2;
    return (mode < 3'd4) && m_run && m_t >= m_D && m_t < m_D + m_W;
  endfunction
  function automatic bit m_trig();
    return (mode < 3'd4) && m_run && m_t == m_D;
  endfunction

  task automatic compare();
    string tag;
    case (mode)
      3'd0: tag = "R2"; 3'd1: tag = "R3"; 3'd2: tag = "R4";
      3'd3: tag = "R5"; 3'd4: tag = "R6"; default: tag = "R13";
    endcase
    chk(out_o == m_out(), {tag, " out_o vs model"}, out_o, m_out());
    chk(out_no == !out_o, "R10 complement", out_no, !out_o);
    chk(trig_o == m_trig(), "R11 trig_o vs model", trig_o, m_trig());
    chk(err_o == m_err, "R9 clamp flag vs model", err_o, m_err);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      if (cmp_on) compare();
      if (out_o && !last_out) begin pulse_cnt++; run_len = 1; end
      else if (out_o) run_len++;
      else if (last_out) last_w = run_len;
      last_out = out_o;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int k;
    void'($urandom(32'h5eed_1234));
    #23;
    // R1 reset state
    chk(out_o == 0, "R1 out_o in reset", out_o, 0);
    chk(out_no == 1, "R1 out_no in reset", out_no, 1);
    chk(trig_o == 0, "R1 trig_o in reset", trig_o, 0);
    chk(err_o == 0, "R1 clamp flag in reset", err_o, 0);
    rst_n = 1;
    step(2);
    cmp_on = 1;

    // R2 free running, 10 pulses in 100 cycles
    per = 10; wid = 4; dly = 3; mode = 0; pulse_cnt = 0;
    step(100);
    chk(pulse_cnt == 10, "R2 pulse count", pulse_cnt, 10);
    chk(last_w == 4, "R2 pulse width", last_w, 4);
    mode = 5; step(5);

    // R12 width change mid frame
    per = 20; wid = 4; dly = 8; mode = 0;
    step(3); wid = 9;
    step(19);
    chk(last_w == 4, "R12 running pulse unchanged", last_w, 4);
    step(20);
    chk(last_w == 9, "R12 next frame picks new width", last_w, 9);
    mode = 5; step(5);

    // R3 edge latency and ignored edges
    per = 12; wid = 3; dly = 5; mode = 1; step(2);
    ext = 1; k = 0;
    do begin step(1); k++; end while (!out_o && k < 50);
    chk(k == 5 + 3, "R3 edge latency", k, 8);
    pulse_cnt = 1;
    ext = 0; step(1); ext = 1; step(1); ext = 0;
    step(30);
    chk(pulse_cnt == 1, "R3 edge during frame ignored", pulse_cnt, 1);
    ext = 1; step(30); ext = 0;
    chk(pulse_cnt == 2, "R3 edge when idle", pulse_cnt, 2);
    step(5);

    // R4 level gate
    per = 10; wid = 3; dly = 0; mode = 2; pulse_cnt = 0;
    ext = 1; step(35); ext = 0; step(40);
    chk(pulse_cnt == 4, "R4 level pulses then stop", pulse_cnt, 4);

    // R5 software trigger
    per = 10; wid = 2; dly = 1; mode = 3; pulse_cnt = 0;
    sw = 1; step(1); sw = 0; step(30);
    chk(pulse_cnt == 1, "R5 one pulse per command", pulse_cnt, 1);
    sw = 1; step(1); sw = 0; step(2); sw = 1; step(1); sw = 0; step(30);
    chk(pulse_cnt == 2, "R5 command during frame ignored", pulse_cnt, 2);
    chk(err_o == 0, "R9 no clamp yet", err_o, 0);

    // R6 external width passthrough
    mode = 4; step(3); ext = 1; step(1);
    chk(out_o == 0, "R6 passthrough after one edge", out_o, 0);
    step(1);
    chk(out_o == 1, "R6 passthrough after two edges", out_o, 1);
    chk(trig_o == 0, "R6 no trig_o", trig_o, 0);
    ext = 0; step(3);

    // R7 width clamp high and low
    per = 10; wid = 9; dly = 0; mode = 0; step(25);
    chk(last_w == 8, "R7 width clamped to P-G", last_w, 8);
    chk(err_o == 1, "R9 flag set on clamp", err_o, 1);
    wid = 1; step(25);
    chk(last_w == 2, "R7 width clamped to G", last_w, 2);
    // R8 period floor
    per = 0; wid = 2; dly = 0; pulse_cnt = 0; step(8);
    pulse_cnt = 0; step(40);
    chk(pulse_cnt == 10, "R8 period floor of 2G", pulse_cnt, 10);
    mode = 5; step(6);
    // R8 delay limit via edge latency
    per = 10; wid = 4; dly = 9; mode = 1; step(2);
    ext = 1; k = 0;
    do begin step(1); k++; end while (!out_o && k < 50);
    chk(k == 6 + 3, "R8 delay limited to P-W", k, 9);
    ext = 0; step(15);
    chk(err_o == 1, "R9 flag sticky", err_o, 1);

    // R13 reserved modes
    mode = 6; step(10);
    chk(out_o == 0 && trig_o == 0, "R13 reserved mode idle", out_o, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) mode = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 20) == 0) begin
        per = 8'($urandom_range(0, 40));
        wid = 8'($urandom_range(0, 45));
        dly = 8'($urandom_range(0, 45));
      end
      sw  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 6) == 0) ext = ~ext;
      step(1);
    end
    finish_run();
  end
endmodule